// File: doc/BRIEF.md
# Address Window Translation Unit

This unit sits between an upstream bus and a downstream fabric and rewrites upstream addresses into the downstream address space. It has a configurable number of windows, six by default. Software programs each window through three 32-bit registers: a base address on the upstream side, a length counted in 4 KB pages, and a target base. A window whose length is zero is switched off.

On every lookup the unit compares the address against all windows in parallel. The lowest-numbered window that matches is chosen, and the unit returns its number together with the translated address. If no window matches, the unit raises a decode-error pulse. The target-base register supports two encodings, chosen by its bit 0:
- **Plain byte base:** used for the configuration and I/O style windows, where the target is a fixed high prefix such as 0xFDFC0000.
- **Page-number encoding:** used for memory windows. The target page sits in bits [31:4] and bit 0 is set to 1.

The lookup result appears one clock after the request.

Top module: `awin_xlate`

## Requirements
- R1: After reset every register reads 0, and every lookup misses.
- R2: The register map places the length of window i at byte offset 4*i, its upstream base at 4*(NWIN+i), and its target base at 4*(2*NWIN+i). Each written value reads back unchanged.
- R3: A window whose length register is 0 never matches any address.
- R4: An address A matches window i exactly when base_i <= A < base_i + length_i*4096. The window is therefore hit at its base and at its last byte, and missed one byte below its base and one byte past its end.
- R5: When target-base bit 0 is 0, the translated address is target_base + (A - base_i), modulo 2^32.
- R6: When target-base bit 0 is 1, the translated address is (target_base[31:4] << 12) + (A - base_i), truncated to 32 bits.
- R7: When several windows match, the result reports the lowest-numbered one, in rsp_win, and uses that window's translation.
- R8: On a miss, rsp_hit is 0, rsp_win and rsp_addr are 0, and rsp_decerr is high for exactly that one result cycle. rsp_decerr is never high on a hit or when no result is presented.
- R9: A lookup presented with lk_valid in cycle N produces rsp_valid in cycle N+1. rsp_valid is low in any cycle that follows a cycle without lk_valid.
- R10: A write to an offset outside the map, or with reg_addr[1:0] not 0, changes no register, and such an offset reads as 0.
- R11: A register write takes effect on the clock edge that accepts it. A lookup presented in the same cycle as the write is translated with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Upstream address to translate |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Some window matched |
| rsp_win | output | 3 | Winning window number |
| rsp_addr | output | 32 | Translated downstream address |
| rsp_decerr | output | 1 | Decode-error pulse on a miss |

## Verification
Every lookup result is due in the clock cycle after the cycle that presented lk_valid. The driver computes each expected result from its own shadow copy of the registers at the moment it presents the request, then queues it. The monitor samples at the falling edge of each cycle in which rsp_valid is set and pops exactly one queued item, so an early, late or extra result shows up as a mismatch or as a queue left over at the end. The shadow copy is updated only after the write edge, so a lookup in the same cycle as a write is scored against the old setting. Register read data is combinational and is sampled one nanosecond after reg_addr changes.

// File: rtl/awin_pkg.sv
package awin_pkg;
  localparam int unsigned AWIN_DW = 32;
  localparam int unsigned AWIN_PG = 12;

  // True when a lies inside [s, s + sz pages)
  function automatic logic awin_in_window(input logic [AWIN_DW-1:0] a,
                                          input logic [AWIN_DW-1:0] s,
                                          input logic [AWIN_DW-1:0] sz);
    logic [AWIN_DW:0] diff;
    logic [AWIN_DW+AWIN_PG-1:0] lim;
    diff = {1'b0, a} - {1'b0, s};
    lim  = {sz, {AWIN_PG{1'b0}}};
    return (sz != '0) && !diff[AWIN_DW] &&
           ({{AWIN_PG{1'b0}}, diff[AWIN_DW-1:0]} < lim);
  endfunction

  // Downstream address from window base and target encoding
  function automatic logic [AWIN_DW-1:0] awin_form(input logic [AWIN_DW-1:0] a,
                                                   input logic [AWIN_DW-1:0] s,
                                                   input logic [AWIN_DW-1:0] t);
    logic [AWIN_DW-1:0] off;
    logic [AWIN_DW-1:0] base;
    off = a - s;
    if (t[0]) base = (t >> 4) << AWIN_PG;
    else      base = t;
    return base + off;
  endfunction
endpackage

// File: rtl/awin_regfile.sv
module awin_regfile
  import awin_pkg::*;
#(
  parameter int unsigned NWIN   = 6,
  parameter int unsigned REG_AW = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [REG_AW-1:0]                reg_addr,
  input  logic [AWIN_DW-1:0]               reg_wdata,
  output logic [AWIN_DW-1:0]               reg_rdata,
  output logic [NWIN-1:0][AWIN_DW-1:0]     size_o,
  output logic [NWIN-1:0][AWIN_DW-1:0]     start_o,
  output logic [NWIN-1:0][AWIN_DW-1:0]     tgt_o,
  output logic [NWIN-1:0]                  win_en_o
);
  localparam int unsigned SIZE_OFS  = 0;
  localparam int unsigned START_OFS = 4 * NWIN;
  localparam int unsigned TGT_OFS   = 8 * NWIN;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [REG_AW-1:0] A_SZ = REG_AW'(SIZE_OFS + 4 * i);
    localparam logic [REG_AW-1:0] A_ST = REG_AW'(START_OFS + 4 * i);
    localparam logic [REG_AW-1:0] A_TG = REG_AW'(TGT_OFS + 4 * i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_o[i]  <= '0;
        start_o[i] <= '0;
        tgt_o[i]   <= '0;
      end else if (reg_wr) begin
        if (reg_addr == A_SZ) size_o[i]  <= reg_wdata;
        if (reg_addr == A_ST) start_o[i] <= reg_wdata;
        if (reg_addr == A_TG) tgt_o[i]   <= reg_wdata;
      end
    end

    assign win_en_o[i] = (size_o[i] != '0);
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (reg_addr == REG_AW'(SIZE_OFS + 4 * i))  reg_rdata = size_o[i];
      if (reg_addr == REG_AW'(START_OFS + 4 * i)) reg_rdata = start_o[i];
      if (reg_addr == REG_AW'(TGT_OFS + 4 * i))   reg_rdata = tgt_o[i];
    end
  end
endmodule

// File: rtl/awin_match.sv
module awin_match
  import awin_pkg::*;
#(
  parameter int unsigned NWIN = 6
) (
  input  logic [AWIN_DW-1:0]           lk_addr,
  input  logic [NWIN-1:0][AWIN_DW-1:0] size_i,
  input  logic [NWIN-1:0][AWIN_DW-1:0] start_i,
  input  logic [NWIN-1:0][AWIN_DW-1:0] tgt_i,
  output logic [NWIN-1:0]              match_o,
  output logic [NWIN-1:0][AWIN_DW-1:0] xaddr_o
);
  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign match_o[i] = awin_in_window(lk_addr, start_i[i], size_i[i]);
    assign xaddr_o[i] = awin_form(lk_addr, start_i[i], tgt_i[i]);
  end
endmodule

// File: rtl/awin_resolve.sv
module awin_resolve
  import awin_pkg::*;
#(
  parameter int unsigned NWIN  = 6,
  parameter int unsigned WIN_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_valid,
  input  logic [NWIN-1:0]              match_i,
  input  logic [NWIN-1:0][AWIN_DW-1:0] xaddr_i,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [WIN_W-1:0]             rsp_win,
  output logic [AWIN_DW-1:0]           rsp_addr,
  output logic                         rsp_decerr
);
  logic               any_hit;
  logic [WIN_W-1:0]   sel_win;
  logic [AWIN_DW-1:0] sel_addr;

  // scan downward so the lowest index is written last and wins
  always_comb begin
    any_hit  = 1'b0;
    sel_win  = '0;
    sel_addr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        any_hit  = 1'b1;
        sel_win  = WIN_W'(i);
        sel_addr = xaddr_i[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_win    <= '0;
      rsp_addr   <= '0;
      rsp_decerr <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && any_hit;
      rsp_win    <= lk_valid ? sel_win : '0;
      rsp_addr   <= lk_valid ? sel_addr : '0;
      rsp_decerr <= lk_valid && !any_hit;
    end
  end
endmodule

// File: rtl/awin_xlate.sv
module awin_xlate
  import awin_pkg::*;
#(
  parameter int unsigned NWIN   = 6,
  parameter int unsigned REG_AW = 8,
  localparam int unsigned WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               lk_valid,
  input  logic [31:0]        lk_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [WIN_W-1:0]   rsp_win,
  output logic [31:0]        rsp_addr,
  output logic               rsp_decerr
);
  logic [NWIN-1:0][AWIN_DW-1:0] size_w;
  logic [NWIN-1:0][AWIN_DW-1:0] start_w;
  logic [NWIN-1:0][AWIN_DW-1:0] tgt_w;
  logic [NWIN-1:0][AWIN_DW-1:0] xaddr_w;
  logic [NWIN-1:0]              win_en;
  logic [NWIN-1:0]              match_vec;

  awin_regfile #(.NWIN(NWIN), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .size_o(size_w), .start_o(start_w), .tgt_o(tgt_w), .win_en_o(win_en)
  );

  awin_match #(.NWIN(NWIN)) match_i (
    .lk_addr(lk_addr), .size_i(size_w), .start_i(start_w), .tgt_i(tgt_w),
    .match_o(match_vec), .xaddr_o(xaddr_w)
  );

  awin_resolve #(.NWIN(NWIN), .WIN_W(WIN_W)) res_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .match_i(match_vec), .xaddr_i(xaddr_w),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_addr(rsp_addr), .rsp_decerr(rsp_decerr)
  );
endmodule

// File: rtl/awin_xlate_chk.sv
module awin_xlate_chk #(
  parameter int unsigned NWIN  = 6,
  parameter int unsigned WIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_decerr,
  input logic [WIN_W-1:0] rsp_win,
  input logic [NWIN-1:0]  match_vec,
  input logic [NWIN-1:0]  win_en
);
  // R8
  decerr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_decerr |-> (rsp_valid && !rsp_hit));
  // R8
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_decerr);
  // R9
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R9
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R3
  disabled_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~win_en) == '0);
  // R7
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_win) < NWIN));
  // R8
  miss_win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_win == '0));
endmodule

bind awin_xlate awin_xlate_chk #(.NWIN(NWIN), .WIN_W(WIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_decerr(rsp_decerr), .rsp_win(rsp_win),
  .match_vec(match_vec), .win_en(win_en)
);

// File: tb/awin_xlate_tb_top.sv
module awin_xlate_tb_top;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_decerr;
  logic [2:0]  rsp_win;
  logic [31:0] rsp_addr;

  always #2 clk = ~clk;

  awin_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_decerr(rsp_decerr)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] sh_sz [NW];
  logic [31:0] sh_st [NW];
  logic [31:0] sh_tg [NW];

  typedef struct {
    bit          hit;
    int          win;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    e.hit = 0; e.win = 0; e.addr = 0; e.tag = tag;
    for (int i = 0; i < NW; i++) begin
      longint unsigned lo, len;
      lo  = longint'(sh_st[i]);
      len = longint'(sh_sz[i]) * 64'd4096;
      if (!e.hit && len != 0 && longint'(a) >= lo && longint'(a) < lo + len) begin
        e.hit = 1; e.win = i;
        if (sh_tg[i][0])
          e.addr = 32'((longint'(sh_tg[i]) / 16) * 4096 + (longint'(a) - lo));
        else
          e.addr = 32'(longint'(sh_tg[i]) + (longint'(a) - lo));
      end
    end
    return e;
  endfunction

  task automatic shadow_write(input logic [7:0] wa, input logic [31:0] wd);
    int idx;
    if (wa[1:0] == 2'b00 && wa < 8'(12 * NW)) begin
      idx = int'(wa) / 4;
      if (idx < NW)          sh_sz[idx] = wd;
      else if (idx < 2 * NW) sh_st[idx - NW] = wd;
      else                   sh_tg[idx - 2 * NW] = wd;
    end
  endtask

  // one cycle: optional write, optional lookup; entered right after a negedge
  task automatic step(input bit wr, input logic [7:0] wa, input logic [31:0] wd,
                      input bit lk, input logic [31:0] la, input string tag);
    reg_wr = wr; reg_addr = wa; reg_wdata = wd;
    lk_valid = lk; lk_addr = la;
    if (lk) q.push_back(predict(la, tag));
    @(posedge clk);
    if (wr) shadow_write(wa, wd);
    @(negedge clk);
    reg_wr = 0; lk_valid = 0;
  endtask

  task automatic wr(input logic [7:0] wa, input logic [31:0] wd);
    step(1, wa, wd, 0, 0, "");
  endtask

  task automatic look(input logic [31:0] la, input string tag);
    step(0, 0, 0, 1, la, tag);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    #1;
    n_run++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: reg 0x%0h read 0x%08h expected 0x%08h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic set_win(input int i, input logic [31:0] st, input logic [31:0] sz,
                         input logic [31:0] tg);
    wr(8'(4 * i), sz);
    wr(8'(4 * (NW + i)), st);
    wr(8'(4 * (2 * NW + i)), tg);
  endtask

  // monitor: score each result in the cycle it is due
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      n_run++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: unexpected result actual addr=0x%08h expected none", rsp_addr);
      end else begin
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_decerr !== !e.hit ||
            int'(rsp_win) != e.win || rsp_addr !== e.addr) begin
          n_fail++;
          $display("FAIL %s: actual hit=%0b err=%0b win=%0d addr=0x%08h expected hit=%0b err=%0b win=%0d addr=0x%08h",
                   e.tag, rsp_hit, rsp_decerr, rsp_win, rsp_addr,
                   e.hit, !e.hit, e.win, e.addr);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) begin sh_sz[i] = 0; sh_st[i] = 0; sh_tg[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3 * NW; i++) rd_chk(8'(4 * i), 32'h0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    look(32'h0000_0000, "R1 miss after reset");
    look(32'h9000_1234, "R1 miss after reset");

    // R2: offsets and read back
    for (int i = 0; i < 3 * NW; i++) wr(8'(4 * i), 32'h5A00_0000 + 32'(i * 17));
    for (int i = 0; i < 3 * NW; i++) rd_chk(8'(4 * i), 32'h5A00_0000 + 32'(i * 17), "R2");
    for (int i = 0; i < 3 * NW; i++) wr(8'(4 * i), 32'h0);

    // R10: out-of-map and misaligned writes are dropped
    wr(8'h48, 32'hDEAD_BEEF);
    rd_chk(8'h48, 32'h0, "R10 unmapped read");
    wr(8'h01, 32'h0000_0010);
    rd_chk(8'h00, 32'h0, "R10 misaligned write ignored");
    look(32'h0000_0100, "R10 no window opened");

    // layout: cfg, ext cfg, io, prefetch, non-prefetch
    set_win(0, 32'h8000_4000, 32'h0000_0100, 32'hFDFF_0000);
    set_win(1, 32'h8010_4000, 32'h0000_0100, 32'hFE10_0000);
    set_win(2, 32'h8040_0000, 32'h0000_0010, 32'hFDFC_0000);
    set_win(3, 32'hA000_0000, 32'h0001_0000, 32'h00A0_0001);
    set_win(4, 32'h9000_0000, 32'h0001_0000, 32'h0090_0001);

    // R4 boundaries, R5 plain, R6 page encoding
    look(32'h8040_0000, "R4 R5 io base");
    look(32'h8040_FFFF, "R4 R5 io last byte");
    look(32'h8041_0000, "R4 io one past end");
    look(32'h803F_FFFF, "R4 io below base");
    look(32'h8000_4123, "R5 cfg");
    look(32'h8010_7FFC, "R5 ext cfg");
    look(32'h9000_0000, "R6 mem base");
    look(32'h9FFF_FFFF, "R6 mem last byte");
    look(32'hA123_4568, "R6 prefetch");
    look(32'hC000_0000, "R8 past prefetch");
    look(32'h1234_5678, "R8 miss");

    // R7: overlapping window 5 over window 4, lower index wins
    set_win(5, 32'h9800_0000, 32'h0000_1000, 32'h4000_0000);
    look(32'h9800_0010, "R7 overlap lowest wins");
    look(32'h9900_0010, "R7 overlap beyond lower end");
    // R3: disable window 4, window 5 takes over
    wr(8'h10, 32'h0);
    look(32'h9800_0010, "R3 disabled window skipped");
    look(32'h9000_0000, "R3 disabled window misses");

    // R11: write and lookup in the same cycle use the old setting
    step(1, 8'h10, 32'h0001_0000, 1, 32'h9000_0040, "R11 same cycle old value");
    look(32'h9000_0040, "R11 new value next cycle");

    // R9: back-to-back lookups then a gap
    look(32'h8040_0004, "R9 b2b first");
    look(32'h8000_4008, "R9 b2b second");
    @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: rsp_valid actual %0b expected 0 after idle", rsp_valid);
    end

    repeat (3) @(negedge clk);
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R9: %0d results missing, expected 0", q.size());
    end
    finish_run();
  end
endmodule